// File: doc/BRIEF.md
# Multicore Reset and Boot Controller

This block is a memory-mapped register bank that governs the bring-up, shutdown and reset of up to four processor cores, plus two peripheral subsystems that need only a software reset. Software talks to it over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. The bank holds a control word, two boot-mode words, a reset-status word, an interrupt status word, an interrupt mask word and ten general-purpose words.

A write to the control word does not simply store the value. The block XORs the incoming value with the stored one and acts only on the bits that differ. A core enable bit that flips causes a one-cycle start or stop request to that core. The boot address and context word come from a pair of general-purpose words assigned to that core. A core reset bit that flips causes a one-cycle reset request. That bit then stays set until the core returns an acknowledge. The two peripheral reset bits take effect at once and are never stored as set.

Top module: `core_boot_ctrl`

## Requirements
- R1: After a synchronous reset, word 0 (control) reads 0x00000521, word 2 (reset status) reads 0x00000001, word 4 (interrupt mask) reads 0x0000001F, and every other word of the 16 reads 0.
- R2: A word is selected by byte address bits [11:2], so word k sits at byte offset 4k. Word 1 and word 5 are the boot-mode words and word 3 is the interrupt status. General-purpose word g (g = 1..10) is word 5+g. A read with a word index of 16 or more, or with address bits [1:0] not zero, returns 0.
- R3: A write with a word index of 16 or more, or with address bits [1:0] not zero, changes no word. Such a write drives `bus_err` high for exactly the one cycle after the write edge.
- R4: A write to any word other than the control word stores the write data unchanged and raises no request.
- R5: A control write that changes the enable bit of core N (N = 1..3; bits 22, 23, 24) from 0 to 1 raises `core_start[N]` for the one cycle after the write edge. While that pulse is high, `core_boot_addr` slice N holds general-purpose word 2N+1 and `core_ctx` slice N holds general-purpose word 2N+2.
- R6: A control write that changes the enable bit of core N from 1 to 0 raises `core_stop[N]` for the one cycle after the write edge.
- R7: A control write that changes no action bit raises no request and no error.
- R8: A control write that changes the reset bit of core n (n = 0..3; bits 13, 14, 15, 16) raises `core_rst_req[n]` for one cycle after the write edge. The stored reset bit keeps its written value until acknowledged.
- R9: If the same control write also changes that core's enable bit, no reset request is raised for that core. Only the start or stop request is raised.
- R10: A high `core_ack[n]` clears the stored reset bit of core n at that edge. This takes priority over a control write in the same cycle that writes the bit as 1.
- R11: A control write that changes a peripheral reset bit (bits 3 and 12) stores that bit as 0. Both bits therefore always read back as 0.
- R12: Every request output and `bus_err` is a single-cycle pulse. Start and stop are never high together for one core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bus_err | output | 1 | One-cycle pulse after a rejected write |
| core_ack | input | 4 | Per-core completion acknowledge |
| core_start | output | 4 | Per-core start request pulse (bit 0 unused, always 0) |
| core_stop | output | 4 | Per-core power-off request pulse (bit 0 unused, always 0) |
| core_rst_req | output | 4 | Per-core reset request pulse |
| core_boot_addr | output | 128 | Boot address per core, 32 bits per core, core 0 slice zero |
| core_ctx | output | 128 | Context word per core, 32 bits per core, core 0 slice zero |

## Verification
The assertions assume the bus never changes address or data in the middle of a cycle, so every write is one clean edge. They also assume that `core_ack` is a single-cycle strobe that is not held across edges. The acknowledge rule is checked as an unconditional clear. It is valid for any acknowledge pattern, including one that arrives with no request outstanding. The stimulus holds `bus_we` and `core_ack` high for exactly one edge each. It changes inputs one nanosecond after the rising edge, and it compares results at the falling edge against a register model kept inside the bench.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;
    parameter int unsigned DATA_W    = 32;
    parameter int unsigned ADDR_W    = 12;
    parameter int unsigned NUM_REGS  = 16;
    parameter int unsigned NUM_CORES = 4;
    parameter int unsigned NUM_PERIPH = 2;

    localparam int unsigned IDX_W     = ADDR_W - 2;
    localparam int unsigned SEL_W     = $clog2(NUM_REGS);
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_RSTAT = 2;
    localparam int unsigned IDX_IMASK = 4;
    localparam int unsigned IDX_GPR1  = 6;

    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [NUM_CORES-1:0] core_vec_t;

    localparam word_t CTRL_INIT  = 32'h0000_0521;
    localparam word_t RSTAT_INIT = 32'h0000_0001;
    localparam word_t IMASK_INIT = 32'h0000_001F;

    // Control bit map; entry 0 of the enable table is unused (core 0 is always on)
    localparam int unsigned CORE_RST_BIT [NUM_CORES]  = '{13, 14, 15, 16};
    localparam int unsigned CORE_EN_BIT  [NUM_CORES]  = '{0, 22, 23, 24};
    localparam int unsigned PERIPH_BIT   [NUM_PERIPH] = '{3, 12};

    typedef struct packed {
        core_vec_t start;
        core_vec_t stop;
        core_vec_t rst;
    } core_req_t;

    // General-purpose word 2N+1 holds the boot address of core N
    function automatic int unsigned boot_idx(int unsigned core);
        return IDX_GPR1 + 2 * core;
    endfunction

    // General-purpose word 2N+2 holds the context word of core N
    function automatic int unsigned ctx_idx(int unsigned core);
        return IDX_GPR1 + 2 * core + 1;
    endfunction

    function automatic word_t init_value(int unsigned idx);
        case (idx)
            IDX_CTRL:  return CTRL_INIT;
            IDX_RSTAT: return RSTAT_INIT;
            IDX_IMASK: return IMASK_INIT;
            default:   return '0;
        endcase
    endfunction
endpackage

// File: rtl/cbc_regfile.sv
`timescale 1ns/1ps
module cbc_regfile
    import cbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  word_t            wr_data,
    input  logic             ctrl_load,
    input  word_t            ctrl_next,
    input  logic             rd_ok,
    input  logic [SEL_W-1:0] rd_sel,
    output word_t            rd_data,
    output word_t            regs_o [NUM_REGS]
);
    word_t regs_q [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
            if (i == IDX_CTRL) begin : g_ctrl
                always_ff @(posedge clk) begin
                    if (rst)            regs_q[i] <= init_value(i);
                    else if (ctrl_load) regs_q[i] <= ctrl_next;
                end
            end else begin : g_plain
                always_ff @(posedge clk) begin
                    if (rst)                                     regs_q[i] <= init_value(i);
                    else if (wr_en && wr_sel == SEL_W'(i))       regs_q[i] <= wr_data;
                end
            end
            assign regs_o[i] = regs_q[i];
        end
    endgenerate

    assign rd_data = rd_ok ? regs_q[rd_sel] : '0;
endmodule

// File: rtl/cbc_action.sv
`timescale 1ns/1ps
module cbc_action
    import cbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  word_t     wdata,
    input  word_t     ctrl_q,
    input  core_vec_t ack,
    output word_t     ctrl_next,
    output logic      ctrl_load,
    output core_req_t req_q
);
    word_t     chg;
    core_vec_t en_chg;
    core_req_t req_d;

    always_comb begin
        chg       = ctrl_q ^ wdata;
        ctrl_next = wr_ctrl ? wdata : ctrl_q;
        req_d     = '0;
        en_chg    = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (c != 0) en_chg[c] = wr_ctrl && chg[CORE_EN_BIT[c]];
            req_d.start[c] = en_chg[c] && wdata[CORE_EN_BIT[c]];
            req_d.stop[c]  = en_chg[c] && !wdata[CORE_EN_BIT[c]];
            // an enable change consumes this core's reset-bit change
            req_d.rst[c]   = wr_ctrl && chg[CORE_RST_BIT[c]] && !en_chg[c];
        end
        for (int p = 0; p < NUM_PERIPH; p++) begin
            if (wr_ctrl && chg[PERIPH_BIT[p]]) ctrl_next[PERIPH_BIT[p]] = 1'b0;
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (ack[c]) ctrl_next[CORE_RST_BIT[c]] = 1'b0;
        end
    end

    assign ctrl_load = wr_ctrl || (|ack);

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    // R12
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.start & req_q.stop) == '0);

    // R9
    rst_vs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.rst & (req_q.start | req_q.stop) & core_vec_t'(4'b1110)) == '0);

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        (req_q.start != '0) |=> (($past(req_q.start) & req_q.start) == '0));
endmodule

// File: rtl/core_boot_ctrl.sv
`timescale 1ns/1ps
module core_boot_ctrl
    import cbc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_err,
    input  logic [NUM_CORES-1:0]        core_ack,
    output logic [NUM_CORES-1:0]        core_start,
    output logic [NUM_CORES-1:0]        core_stop,
    output logic [NUM_CORES-1:0]        core_rst_req,
    output logic [NUM_CORES*DATA_W-1:0] core_boot_addr,
    output logic [NUM_CORES*DATA_W-1:0] core_ctx
);
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic [SEL_W-1:0] sel;
    logic             wr_ok;
    logic             wr_ctrl;
    logic             err_q;
    word_t            ctrl_next;
    logic             ctrl_load;
    core_req_t        req_q;
    word_t            regs [NUM_REGS];

    assign idx     = bus_addr[ADDR_W-1:2];
    assign hit     = (idx < IDX_W'(NUM_REGS)) && (bus_addr[1:0] == 2'b00);
    assign sel     = idx[SEL_W-1:0];
    assign wr_ok   = bus_we && hit;
    assign wr_ctrl = wr_ok && (sel == SEL_W'(IDX_CTRL));

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= bus_we && !hit;
    end
    assign bus_err = err_q;

    cbc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ok),
        .wr_sel    (sel),
        .wr_data   (bus_wdata),
        .ctrl_load (ctrl_load),
        .ctrl_next (ctrl_next),
        .rd_ok     (hit),
        .rd_sel    (sel),
        .rd_data   (bus_rdata),
        .regs_o    (regs)
    );

    cbc_action u_act (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .ctrl_q    (regs[IDX_CTRL]),
        .ack       (core_ack),
        .ctrl_next (ctrl_next),
        .ctrl_load (ctrl_load),
        .req_q     (req_q)
    );

    assign core_start   = req_q.start;
    assign core_stop    = req_q.stop;
    assign core_rst_req = req_q.rst;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            if (c == 0) begin : g_boot_core
                assign core_boot_addr[c*DATA_W +: DATA_W] = '0;
                assign core_ctx[c*DATA_W +: DATA_W]       = '0;
            end else begin : g_sec_core
                assign core_boot_addr[c*DATA_W +: DATA_W] = regs[boot_idx(c)];
                assign core_ctx[c*DATA_W +: DATA_W]       = regs[ctx_idx(c)];
            end

            // R10
            ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
                core_ack[c] |=> !regs[IDX_CTRL][CORE_RST_BIT[c]]);
        end

        for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
            // R11
            periph_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_ctrl && (regs[IDX_CTRL][PERIPH_BIT[p]] != bus_wdata[PERIPH_BIT[p]]))
                |=> !regs[IDX_CTRL][PERIPH_BIT[p]]);
        end
    endgenerate

    // R3
    bad_write_err_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit) |=> bus_err);

    // R12
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !$past(bus_we && !hit)) == 1'b0);
endmodule

// File: tb/core_boot_ctrl_tb.sv
`timescale 1ns/1ps
module core_boot_ctrl_tb;
    typedef struct {
        int         due;
        logic [3:0] st;
        logic [3:0] sp;
        logic [3:0] rs;
        logic       err;
        string      tag;
    } exp_t;

    logic         clk = 0;
    logic         rst = 1;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [3:0]   core_ack = '0;
    logic [3:0]   core_start, core_stop, core_rst_req;
    logic [127:0] core_boot_addr, core_ctx;

    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    bit           mon_on = 0;
    exp_t         sb [$];
    logic [31:0]  mdl [16];
    logic [31:0]  ctrl_m;

    core_boot_ctrl u_dut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ack,
                      input logic [3:0] st, input logic [3:0] sp, input logic [3:0] rs,
                      input logic err, input string tag);
        exp_t e;
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1; core_ack = ack;
        e.due = cyc + 1; e.st = st; e.sp = sp; e.rs = rs; e.err = err; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        bus_we = 0; core_ack = '0;
    endtask

    task automatic ack_only(input logic [3:0] ack);
        @(posedge clk); #1;
        core_ack = ack;
        @(posedge clk); #1;
        core_ack = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] expv, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        #2;
        chk(bus_rdata === expv, tag, bus_rdata, expv);
    endtask

    // scoreboard monitor: pops due items, otherwise expects quiet outputs
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(core_start === e.st, {e.tag, " start"}, 32'(core_start), 32'(e.st));
                chk(core_stop === e.sp, {e.tag, " stop"}, 32'(core_stop), 32'(e.sp));
                chk(core_rst_req === e.rs, {e.tag, " rst_req"}, 32'(core_rst_req), 32'(e.rs));
                chk(bus_err === e.err, {e.tag, " err"}, 32'(bus_err), 32'(e.err));
                for (int c = 1; c < 4; c++) begin
                    if (e.st[c]) begin
                        chk(core_boot_addr[c*32 +: 32] === mdl[6+2*c], "R5 boot addr",
                            core_boot_addr[c*32 +: 32], mdl[6+2*c]);
                        chk(core_ctx[c*32 +: 32] === mdl[7+2*c], "R5 ctx",
                            core_ctx[c*32 +: 32], mdl[7+2*c]);
                    end
                end
            end else begin
                // R12 pulses only where expected
                chk({core_start, core_stop, core_rst_req, bus_err} === 13'd0, "R12 quiet",
                    32'({core_start, core_stop, core_rst_req, bus_err}), 32'd0);
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        mdl[0] = 32'h521; mdl[2] = 32'h1; mdl[4] = 32'h1F;
        ctrl_m = 32'h521;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        mon_on = 1;

        // R1 reset state
        for (int i = 0; i < 16; i++) rd(12'(4*i), mdl[i], "R1 reset value");
        // R2 out-of-range and misaligned reads
        rd(12'h040, 32'h0, "R2 read past end");
        rd(12'hFFC, 32'h0, "R2 read top of window");
        rd(12'h002, 32'h0, "R2 misaligned read");

        // R4 plain words
        for (int i = 1; i < 16; i++) begin
            if (i == 2 || i == 4 || i >= 6) begin
                mdl[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0111;
                wr(12'(4*i), mdl[i], 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, "R4 plain write");
            end
        end
        for (int i = 1; i < 16; i++) rd(12'(4*i), mdl[i], "R4 readback");

        // R3 rejected writes
        wr(12'h040, 32'hDEAD_BEEF, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, "R3 oob write");
        rd(12'h000, ctrl_m, "R3 ctrl untouched");
        wr(12'h021, 32'hCAFE_0000, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1, "R3 misaligned write");
        rd(12'h020, mdl[8], "R3 gpr untouched");

        // R7 unchanged control value
        wr(12'h000, ctrl_m, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, "R7 no change");

        // R5 start core 1
        ctrl_m = ctrl_m | (32'h1 << 22);
        wr(12'h000, ctrl_m, 4'h0, 4'b0010, 4'h0, 4'h0, 1'b0, "R5 start core1");
        rd(12'h000, ctrl_m, "R5 ctrl readback");

        // R5 + R8 start cores 2,3 and reset core 0
        ctrl_m = ctrl_m | (32'h1 << 23) | (32'h1 << 24) | (32'h1 << 13);
        wr(12'h000, ctrl_m, 4'h0, 4'b1100, 4'h0, 4'b0001, 1'b0, "R8 rst core0 start 2/3");
        rd(12'h000, ctrl_m, "R8 rst bit held");
        ack_only(4'b0001);
        ctrl_m = ctrl_m & ~(32'h1 << 13);
        rd(12'h000, ctrl_m, "R10 ack clears core0");

        // R6 + R9 stop core 1 while flipping its reset bit
        ctrl_m = (ctrl_m & ~(32'h1 << 22)) | (32'h1 << 14);
        wr(12'h000, ctrl_m, 4'h0, 4'h0, 4'b0010, 4'h0, 1'b0, "R9 stop core1 no rst");
        rd(12'h000, ctrl_m, "R6 ctrl readback");
        ack_only(4'b0010);
        ctrl_m = ctrl_m & ~(32'h1 << 14);
        rd(12'h000, ctrl_m, "R10 ack clears core1");

        // R8 reset cores 2 and 3
        ctrl_m = ctrl_m | (32'h1 << 15) | (32'h1 << 16);
        wr(12'h000, ctrl_m, 4'h0, 4'h0, 4'h0, 4'b1100, 1'b0, "R8 rst core2/3");
        // R10 ack beats same-cycle write of a 1
        wr(12'h000, ctrl_m, 4'b0100, 4'h0, 4'h0, 4'h0, 1'b0, "R10 ack with write");
        ctrl_m = ctrl_m & ~(32'h1 << 15);
        rd(12'h000, ctrl_m, "R10 ack priority");
        ack_only(4'b1000);
        ctrl_m = ctrl_m & ~(32'h1 << 16);
        rd(12'h000, ctrl_m, "R10 ack clears core3");

        // R11 peripheral resets self-clear
        wr(12'h000, ctrl_m | (32'h1 << 3) | (32'h1 << 12), 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, "R11 periph write");
        rd(12'h000, ctrl_m, "R11 periph reads zero");

        repeat (3) @(posedge clk);
        #1;
        chk(sb.size() == 0, "R12 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule